// File: doc/BRIEF.md
# Stereo PDM Microphone Capture Interface

This block drives the clock for one or two pulse-density-modulated digital microphones and collects their one-bit output from a single shared data pin. It runs from the 24 MHz link bit clock. It divides that clock down to one of three microphone clock rates, chosen at run time, and every rate has an even duty cycle. A downstream decimation filter receives a one-bit sample per channel, each paired with a single-cycle valid strobe. The strobe rate therefore equals the microphone clock rate.

Sampling happens only at the system edge where the microphone clock itself changes level. The captured value is the data that was on the pin just before that edge, which meets the microphone's setup and hold window. In stereo (shared-pin) mode, the right channel is taken at each rising edge and the left channel at each falling edge. In mono mode, only the rising edge is used and the result goes to the left output. An enable input parks the microphone clock low and mutes both strobes. When enable returns, the clock restarts cleanly from the low phase.

Top module: `pdm_mic_capture`

## Requirements
- R1: rate_sel selects the microphone clock half-period in system cycles: 00 gives 8 (1.5 MHz), 01 gives 6 (2.0 MHz), 10 and 11 give 4 (3.0 MHz).
- R2: While enabled, every high phase and every low phase of mic_clk_out lasts exactly the selected half-period. The only exception is the first low phase after a restart.
- R3: A new rate_sel value is taken only at a falling edge of mic_clk_out, or while disabled. The period in progress always finishes at the old rate.
- R4: With enable low, mic_clk_out is low from the next cycle on and both valid strobes stay low. In the first cycle after enable rises, mic_clk_out is still low.
- R5: In stereo mode (stereo_mode=1), right_valid pulses for one cycle in the same cycle that mic_clk_out goes high. right_bit then equals mic_data_in as sampled at that system edge.
- R6: In stereo mode, left_valid pulses for one cycle in the same cycle that mic_clk_out goes low. left_bit then equals mic_data_in as sampled at that edge.
- R7: In mono mode (stereo_mode=0), left_valid pulses at each rising edge of mic_clk_out with the data sampled there, and right_valid never pulses.
- R8: After reset all outputs are 0. left_bit and right_bit keep their value in every cycle in which their own valid strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24 MHz system (link bit) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the microphone clock and capture when high |
| rate_sel | input | 2 | Microphone clock rate select |
| stereo_mode | input | 1 | 1 = two microphones share the pin, 0 = one microphone |
| mic_data_in | input | 1 | Shared microphone data pin |
| mic_clk_out | output | 1 | Microphone clock |
| left_bit | output | 1 | Last captured left-channel bit |
| left_valid | output | 1 | One-cycle strobe for a new left bit |
| right_bit | output | 1 | Last captured right-channel bit |
| right_valid | output | 1 | One-cycle strobe for a new right bit |

## Verification
The bench builds the block with its default half-periods of 8, 6 and 4 cycles, which are the divisors for a 24 MHz source. All four rate_sel codes can therefore be reached, including the aliased fastest one. With these short periods the bench can switch rates, enable and mode thousands of times, often in the middle of a phase. This exercises the rule that a rate is latched only at a falling edge, and it measures the length of every phase. Fresh random data on each cycle lets the bench tell whether a bit was taken exactly at the clock edge or one cycle off.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;

    // Captured sample state for both channels
    typedef struct packed {
        logic lbit;
        logic lval;
        logic rbit;
        logic rval;
    } cap_t;

    localparam cap_t CAP_RESET = '{lbit: 1'b0, lval: 1'b0, rbit: 1'b0, rval: 1'b0};

endpackage

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen #(
    parameter int HALF_SLOW = 8,
    parameter int HALF_MID  = 6,
    parameter int HALF_FAST = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] rate_sel,
    output logic       mic_clk,
    output logic       rise_tick,
    output logic       fall_tick
);
    localparam int CNT_W = $clog2(HALF_SLOW + 1);

    typedef struct packed {
        logic             ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] half;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [CNT_W-1:0] half_sel;

    always_comb begin
        case (rate_sel)
            2'b00:   half_sel = CNT_W'(HALF_SLOW);
            2'b01:   half_sel = CNT_W'(HALF_MID);
            default: half_sel = CNT_W'(HALF_FAST);
        endcase
    end

    always_comb begin
        gen_d     = gen_q;
        rise_tick = 1'b0;
        fall_tick = 1'b0;
        if (!enable) begin
            gen_d.ph   = 1'b0;
            gen_d.cnt  = '0;
            gen_d.half = half_sel;
        end else if (gen_q.cnt == gen_q.half - 1'b1) begin
            gen_d.cnt = '0;
            gen_d.ph  = !gen_q.ph;
            if (gen_q.ph) begin
                fall_tick  = 1'b1;
                gen_d.half = half_sel;
            end else begin
                rise_tick = 1'b1;
            end
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '{ph: 1'b0, cnt: '0, half: CNT_W'(HALF_SLOW)};
        end else begin
            gen_q <= gen_d;
        end
    end

    assign mic_clk = gen_q.ph;

endmodule

// File: rtl/pdm_edge_capture.sv
module pdm_edge_capture
    import pdm_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_tick,
    input  logic fall_tick,
    input  logic stereo_mode,
    input  logic din,
    output logic left_bit,
    output logic left_valid,
    output logic right_bit,
    output logic right_valid
);
    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.lval = 1'b0;
        cap_d.rval = 1'b0;
        if (stereo_mode) begin
            if (rise_tick) begin
                cap_d.rbit = din;
                cap_d.rval = 1'b1;
            end
            if (fall_tick) begin
                cap_d.lbit = din;
                cap_d.lval = 1'b1;
            end
        end else if (rise_tick) begin
            cap_d.lbit = din;
            cap_d.lval = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= CAP_RESET;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign left_bit    = cap_q.lbit;
    assign left_valid  = cap_q.lval;
    assign right_bit   = cap_q.rbit;
    assign right_valid = cap_q.rval;

endmodule

// File: rtl/pdm_mic_capture.sv
module pdm_mic_capture #(
    parameter int HALF_SLOW = 8,
    parameter int HALF_MID  = 6,
    parameter int HALF_FAST = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] rate_sel,
    input  logic       stereo_mode,
    input  logic       mic_data_in,
    output logic       mic_clk_out,
    output logic       left_bit,
    output logic       left_valid,
    output logic       right_bit,
    output logic       right_valid
);
    logic rise_tick;
    logic fall_tick;

    pdm_clk_gen #(
        .HALF_SLOW(HALF_SLOW),
        .HALF_MID (HALF_MID),
        .HALF_FAST(HALF_FAST)
    ) u_clk_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .rate_sel (rate_sel),
        .mic_clk  (mic_clk_out),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick)
    );

    pdm_edge_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .stereo_mode(stereo_mode),
        .din        (mic_data_in),
        .left_bit   (left_bit),
        .left_valid (left_valid),
        .right_bit  (right_bit),
        .right_valid(right_valid)
    );

endmodule

// File: rtl/pdm_cap_checker.sv
module pdm_cap_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic [1:0] rate_sel,
    input logic       stereo_mode,
    input logic       mic_data_in,
    input logic       mic_clk_out,
    input logic       left_bit,
    input logic       left_valid,
    input logic       right_bit,
    input logic       right_valid
);
    AST_DISABLED_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !mic_clk_out); // R4

    AST_DISABLED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (!left_valid && !right_valid)); // R4

    AST_RIGHT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        right_valid |-> (mic_clk_out && !$past(mic_clk_out))); // R5

    AST_LEFT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (left_valid && $past(stereo_mode)) |-> (!mic_clk_out && $past(mic_clk_out))); // R6

    AST_RIGHT_MONO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        right_valid |-> $past(stereo_mode)); // R7

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({left_valid, right_valid})); // R6

    AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !left_valid |-> $stable(left_bit)); // R8

    AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !right_valid |-> $stable(right_bit)); // R8

endmodule

bind pdm_mic_capture pdm_cap_checker u_chk (.*);

// File: tb/pdm_mic_capture_bench.sv
module pdm_mic_capture_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       stereo_mode = 1'b1;
    logic       mic_data_in = 1'b0;
    logic       mic_clk_out, left_bit, left_valid, right_bit, right_valid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pdm_mic_capture u_pdm_mic_capture (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rate_sel(rate_sel),
        .stereo_mode(stereo_mode), .mic_data_in(mic_data_in),
        .mic_clk_out(mic_clk_out), .left_bit(left_bit), .left_valid(left_valid),
        .right_bit(right_bit), .right_valid(right_valid)
    );

    function automatic int half_of(logic [1:0] r);
        case (r)
            2'b00:   return 8;
            2'b01:   return 6;
            default: return 4;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // model state
    bit clk_prev = 0, prev_en = 0, skip = 1, last_drv = 0;
    bit exp_lb = 0, exp_rb = 0;
    int run_len = 0;
    int exp_half = 8;

    task automatic step();
        bit now, en, mux, rose, fell, elv, erv;
        @(negedge clk);
        now  = mic_clk_out;
        en   = enable;
        mux  = stereo_mode;
        rose = now && !clk_prev;
        fell = !now && clk_prev;
        if (!en) begin
            chk(now == 1'b0, "R4 clock low while disabled", now, 0);
        end
        if (en && !prev_en) begin
            chk(now == 1'b0, "R4 restart in low phase", now, 0);
        end
        elv = en && (mux ? fell : rose);
        erv = en && mux && rose;
        chk(left_valid == elv, mux ? "R6 left strobe" : "R7 left strobe", left_valid, elv);
        chk(right_valid == erv, mux ? "R5 right strobe" : "R7 right strobe", right_valid, erv);
        if (elv) exp_lb = last_drv;
        if (erv) exp_rb = last_drv;
        chk(left_bit == exp_lb, elv ? (mux ? "R6 left bit" : "R7 left bit") : "R8 left hold",
            left_bit, exp_lb);
        chk(right_bit == exp_rb, erv ? "R5 right bit" : "R8 right hold", right_bit, exp_rb);
        if (rose || fell) begin
            if (en && !skip) begin
                chk(run_len == exp_half, "R1 R2 R3 phase length", run_len, exp_half);
            end
            run_len = 1;
        end else begin
            run_len++;
        end
        if (!en) begin
            skip = 1;
            exp_half = half_of(rate_sel);
        end else begin
            if (rose || fell) skip = 0;
            if (fell) exp_half = half_of(rate_sel);
        end
        clk_prev = now;
        prev_en  = en;
        last_drv = 1'($urandom);
        mic_data_in = last_drv;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5eed));
        repeat (3) @(negedge clk);
        chk(mic_clk_out == 0, "R8 reset clock", mic_clk_out, 0);
        chk(left_valid == 0 && right_valid == 0, "R8 reset strobes", left_valid, 0);
        chk(left_bit == 0 && right_bit == 0, "R8 reset bits", left_bit, 0);
        rst_n = 1'b1;
        repeat (4) step();
        // directed: each rate code, stereo then mono
        for (int r = 0; r < 4; r++) begin
            rate_sel = 2'(r);
            enable = 1'b0;
            repeat (3) step();
            enable = 1'b1;
            stereo_mode = 1'b1;
            repeat (200) step();
            stereo_mode = 1'b0;
            repeat (200) step();
        end
        // directed: rate change while clock high, disable while clock high
        stereo_mode = 1'b1;
        for (int k = 0; k < 40; k++) begin
            while (!mic_clk_out) step();
            step();
            rate_sel = 2'(k % 3);
            repeat (30) step();
            while (!mic_clk_out) step();
            enable = 1'b0;
            step();
            enable = 1'b1;
            repeat (20) step();
        end
        // random walk
        for (int i = 0; i < 40000; i++) begin
            if ($urandom_range(0, 199) == 0) rate_sel = 2'($urandom);
            if ($urandom_range(0, 299) == 0) stereo_mode = ~stereo_mode;
            if ($urandom_range(0, 399) == 0) enable = ~enable;
            step();
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule